// File: doc/BRIEF.md
# Interface Timing to Tick Converter

This block turns the timing of a parallel display bus, given as ten values in picoseconds, into the two packed tick-count words that a strobe generator decodes, plus a granularity bit. Each value is rounded up to whole ticks of the interface clock. The block then repairs the ordering between the strobe edges and checks that every field fits its width. If a field does not fit with the clock divider set to 1, the whole conversion is repeated with a divider of 2.

A single shared iterative divider handles the fields one after another. A pulse on `start_i` begins a conversion. The period and the ten times must be held stable until `done_o` pulses. When `done_o` is high, `err_o` tells whether the conversion failed. On success the words and the granularity bit are updated in the same cycle.

Top module: `tmc_tick_converter`

## Requirements
- R1: Each field's tick count is ceil(time / (period × D)), where D is the divider under trial. A time of 0 gives 0 ticks.
- R2: On success the strobe word carries CS-on in [3:0], CS-off in [9:4], write-on in [13:10], write-off in [19:14], read-on in [23:20] and read-off in [29:24]. The cycle word carries write-cycle in [5:0], read-cycle in [11:6], CS-pulse in [17:12] and access in [27:22]. All other bits are 0. The words change only in the cycle in which `done_o` is high.
- R3: For the write, read and chip-select strobes, an off tick that is not greater than the matching on tick becomes the on tick plus 1.
- R4: CS-off is raised to at least the larger of write-off and read-off. Access is raised to read-on plus 1 when it is not above read-on. Write-cycle is raised to at least write-off, and read-cycle to at least read-off.
- R5: After repair, an on field above 15, or any other field above 63, makes that divider fail. D=1 is tried first and D=2 second. On success `half_rate_o` = D−1.
- R6: If both dividers fail, `done_o` and `err_o` pulse together and the words and `half_rate_o` keep their previous values.
- R7: A start with a period of 0 gives `done_o` and `err_o` in the next cycle, with no division and no change to the words.
- R8: Take the start as sampled at edge 0, and let c be a field's tick count capped at 64. `done_o` is then high after edge L, where L sums (1 + Σ over the ten fields of (c + 2)) over each divider tried.
- R9: `done_o` is a one-cycle pulse, and `err_o` is high only together with `done_o`.
- R10: After reset the words, `half_rate_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion (ignored while one is running) |
| period_ps_i | input | PER_W | Interface clock period in ps |
| cs_on_ps_i | input | TIME_W | Chip-select assert time |
| cs_off_ps_i | input | TIME_W | Chip-select release time |
| wr_on_ps_i | input | TIME_W | Write strobe assert time |
| wr_off_ps_i | input | TIME_W | Write strobe release time |
| rd_on_ps_i | input | TIME_W | Read strobe assert time |
| rd_off_ps_i | input | TIME_W | Read strobe release time |
| wr_cycle_ps_i | input | TIME_W | Write cycle time |
| rd_cycle_ps_i | input | TIME_W | Read cycle time |
| rd_access_ps_i | input | TIME_W | Read access time |
| cs_pulse_ps_i | input | TIME_W | Chip-select pulse width |
| strobe_word_o | output | 32 | Packed edge ticks |
| cycle_word_o | output | 32 | Packed cycle, pulse and access ticks |
| half_rate_o | output | 1 | Granularity bit (divider − 1) |
| done_o | output | 1 | Conversion finished (pulse) |
| err_o | output | 1 | Conversion failed (with done_o) |

## Verification
The result of a start is due a data-dependent number of cycles later: one cycle for a zero period, otherwise the latency L of R8, summed over the dividers actually tried. The bench computes L and the expected words from the requirements alone, before each start. It then samples the outputs at every falling edge from edge 0 to edge L and one cycle beyond. This confirms that `done_o` stays low before L, pulses exactly at L and drops again, and that the words change only at L.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam int ON_W    = 4;
    localparam int OFF_W   = 6;
    localparam int CNT_W   = OFF_W + 1;
    localparam int NF      = 10;
    localparam int IDX_W   = $clog2(NF);
    localparam int ON_MAX  = (1 << ON_W) - 1;
    localparam int OFF_MAX = (1 << OFF_W) - 1;

    localparam int F_CS_ON    = 0;
    localparam int F_CS_OFF   = 1;
    localparam int F_WR_ON    = 2;
    localparam int F_WR_OFF   = 3;
    localparam int F_RD_ON    = 4;
    localparam int F_RD_OFF   = 5;
    localparam int F_WR_CYC   = 6;
    localparam int F_RD_CYC   = 7;
    localparam int F_ACCESS   = 8;
    localparam int F_CS_PULSE = 9;

    typedef logic [NF-1:0][CNT_W-1:0] tick_vec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_RUN,
        S_CHECK
    } seq_state_e;
endpackage

// File: rtl/tmc_ceil_div.sv
module tmc_ceil_div
    import tmc_pkg::*;
#(
    parameter int TIME_W = 24,
    parameter int STEP_W = 17
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [TIME_W-1:0] dividend_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              fin_o,
    output logic [CNT_W-1:0]  quo_o
);
    localparam int RW = (TIME_W > STEP_W) ? TIME_W : STEP_W;
    localparam logic [CNT_W-1:0] SAT = CNT_W'(1 << OFF_W);

    typedef struct packed {
        logic [RW-1:0]    res;
        logic [RW-1:0]    step;
        logic [CNT_W-1:0] quo;
    } div_t;

    div_t d, q;

    // finished when the residue is used up or the count saturates at 64
    assign fin_o = (q.res == '0) || (q.quo == SAT);
    assign quo_o = q.quo;

    always_comb begin
        d = q;
        if (load_i) begin
            d.res  = RW'(dividend_i);
            d.step = RW'(step_i);
            d.quo  = '0;
        end else if (!fin_o) begin
            d.res = (q.res > q.step) ? (q.res - q.step) : '0;
            d.quo = q.quo + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/tmc_repair.sv
module tmc_repair
    import tmc_pkg::*;
(
    input  tick_vec_t   ticks_i,
    output logic        ok_o,
    output logic [31:0] strobe_word_o,
    output logic [31:0] cycle_word_o
);
    localparam int XW = CNT_W + 1;
    localparam logic [XW-1:0] ONL  = XW'(ON_MAX);
    localparam logic [XW-1:0] OFFL = XW'(OFF_MAX);

    logic [XW-1:0] cs_on, cs_off, wr_on, wr_off, rd_on, rd_off;
    logic [XW-1:0] wr_cyc, rd_cyc, acc, cs_pw, edge_max;

    always_comb begin
        cs_on  = XW'(ticks_i[F_CS_ON]);
        wr_on  = XW'(ticks_i[F_WR_ON]);
        rd_on  = XW'(ticks_i[F_RD_ON]);
        cs_pw  = XW'(ticks_i[F_CS_PULSE]);

        wr_off = XW'(ticks_i[F_WR_OFF]);
        if (wr_off <= wr_on) wr_off = wr_on + XW'(1);
        rd_off = XW'(ticks_i[F_RD_OFF]);
        if (rd_off <= rd_on) rd_off = rd_on + XW'(1);

        cs_off = XW'(ticks_i[F_CS_OFF]);
        if (cs_off <= cs_on) cs_off = cs_on + XW'(1);
        edge_max = (wr_off > rd_off) ? wr_off : rd_off;
        if (cs_off < edge_max) cs_off = edge_max;

        acc = XW'(ticks_i[F_ACCESS]);
        if (acc <= rd_on) acc = rd_on + XW'(1);
        wr_cyc = XW'(ticks_i[F_WR_CYC]);
        if (wr_cyc < wr_off) wr_cyc = wr_off;
        rd_cyc = XW'(ticks_i[F_RD_CYC]);
        if (rd_cyc < rd_off) rd_cyc = rd_off;

        ok_o = (cs_on <= ONL) && (wr_on <= ONL) && (rd_on <= ONL)
            && (cs_off <= OFFL) && (wr_off <= OFFL) && (rd_off <= OFFL)
            && (wr_cyc <= OFFL) && (rd_cyc <= OFFL)
            && (acc <= OFFL) && (cs_pw <= OFFL);

        strobe_word_o = {2'b00, rd_off[OFF_W-1:0], rd_on[ON_W-1:0],
                         wr_off[OFF_W-1:0], wr_on[ON_W-1:0],
                         cs_off[OFF_W-1:0], cs_on[ON_W-1:0]};
        cycle_word_o  = {4'b0000, acc[OFF_W-1:0], 4'b0000, cs_pw[OFF_W-1:0],
                         rd_cyc[OFF_W-1:0], wr_cyc[OFF_W-1:0]};
    end
endmodule

// File: rtl/tmc_seq.sv
module tmc_seq
    import tmc_pkg::*;
#(
    parameter int TIME_W = 24,
    parameter int PER_W  = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [PER_W-1:0]             period_i,
    input  logic [NF-1:0][TIME_W-1:0]    times_i,
    input  logic                         fin_i,
    input  logic [CNT_W-1:0]             quo_i,
    input  logic                         ok_i,
    input  logic [31:0]                  strobe_i,
    input  logic [31:0]                  cycle_i,
    output logic                         load_o,
    output logic [TIME_W-1:0]            dividend_o,
    output logic [PER_W:0]               step_o,
    output tick_vec_t                    ticks_o,
    output logic [31:0]                  strobe_word_o,
    output logic [31:0]                  cycle_word_o,
    output logic                         half_rate_o,
    output logic                         done_o,
    output logic                         err_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NF - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             div2;
        tick_vec_t        ticks;
        logic [31:0]      strobe;
        logic [31:0]      cycle;
        logic             half;
        logic             done;
        logic             err;
    } seq_t;

    seq_t d, q;

    assign dividend_o    = times_i[q.idx];
    assign step_o        = q.div2 ? {period_i, 1'b0} : {1'b0, period_i};
    assign ticks_o       = q.ticks;
    assign strobe_word_o = q.strobe;
    assign cycle_word_o  = q.cycle;
    assign half_rate_o   = q.half;
    assign done_o        = q.done;
    assign err_o         = q.err;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        load_o = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    if (period_i == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.div2  = 1'b0;
                        d.idx   = '0;
                        d.state = S_LOAD;
                    end
                end
            end
            S_LOAD: begin
                load_o  = 1'b1;
                d.state = S_RUN;
            end
            S_RUN: begin
                if (fin_i) begin
                    d.ticks[q.idx] = quo_i;
                    if (q.idx == LAST) begin
                        d.state = S_CHECK;
                    end else begin
                        d.idx   = q.idx + IDX_W'(1);
                        d.state = S_LOAD;
                    end
                end
            end
            S_CHECK: begin
                if (ok_i) begin
                    d.strobe = strobe_i;
                    d.cycle  = cycle_i;
                    d.half   = q.div2;
                    d.done   = 1'b1;
                    d.state  = S_IDLE;
                end else if (!q.div2) begin
                    d.div2  = 1'b1;
                    d.idx   = '0;
                    d.state = S_LOAD;
                end else begin
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/tmc_tick_converter.sv
module tmc_tick_converter
    import tmc_pkg::*;
#(
    parameter int TIME_W = 24,
    parameter int PER_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [PER_W-1:0]  period_ps_i,
    input  logic [TIME_W-1:0] cs_on_ps_i,
    input  logic [TIME_W-1:0] cs_off_ps_i,
    input  logic [TIME_W-1:0] wr_on_ps_i,
    input  logic [TIME_W-1:0] wr_off_ps_i,
    input  logic [TIME_W-1:0] rd_on_ps_i,
    input  logic [TIME_W-1:0] rd_off_ps_i,
    input  logic [TIME_W-1:0] wr_cycle_ps_i,
    input  logic [TIME_W-1:0] rd_cycle_ps_i,
    input  logic [TIME_W-1:0] rd_access_ps_i,
    input  logic [TIME_W-1:0] cs_pulse_ps_i,
    output logic [31:0]       strobe_word_o,
    output logic [31:0]       cycle_word_o,
    output logic              half_rate_o,
    output logic              done_o,
    output logic              err_o
);
    logic [NF-1:0][TIME_W-1:0] times;
    logic                      load, fin, ok;
    logic [TIME_W-1:0]         dividend;
    logic [PER_W:0]            step;
    logic [CNT_W-1:0]          quo;
    tick_vec_t                 ticks;
    logic [31:0]               rep_strobe, rep_cycle;

    always_comb begin
        times[F_CS_ON]    = cs_on_ps_i;
        times[F_CS_OFF]   = cs_off_ps_i;
        times[F_WR_ON]    = wr_on_ps_i;
        times[F_WR_OFF]   = wr_off_ps_i;
        times[F_RD_ON]    = rd_on_ps_i;
        times[F_RD_OFF]   = rd_off_ps_i;
        times[F_WR_CYC]   = wr_cycle_ps_i;
        times[F_RD_CYC]   = rd_cycle_ps_i;
        times[F_ACCESS]   = rd_access_ps_i;
        times[F_CS_PULSE] = cs_pulse_ps_i;
    end

    tmc_seq #(.TIME_W(TIME_W), .PER_W(PER_W)) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .period_i      (period_ps_i),
        .times_i       (times),
        .fin_i         (fin),
        .quo_i         (quo),
        .ok_i          (ok),
        .strobe_i      (rep_strobe),
        .cycle_i       (rep_cycle),
        .load_o        (load),
        .dividend_o    (dividend),
        .step_o        (step),
        .ticks_o       (ticks),
        .strobe_word_o (strobe_word_o),
        .cycle_word_o  (cycle_word_o),
        .half_rate_o   (half_rate_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    tmc_ceil_div #(.TIME_W(TIME_W), .STEP_W(PER_W + 1)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .dividend_i (dividend),
        .step_i     (step),
        .fin_o      (fin),
        .quo_o      (quo)
    );

    tmc_repair u_rep (
        .ticks_i       (ticks),
        .ok_o          (ok),
        .strobe_word_o (rep_strobe),
        .cycle_word_o  (rep_cycle)
    );
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker #(
    parameter int PER_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [PER_W-1:0] period_i,
    input logic [31:0]      strobe_i,
    input logic [31:0]      cycle_i,
    input logic             half_i,
    input logic             done_i,
    input logic             err_i
);
    // R9: error is only reported together with done
    a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |-> done_i);

    // R9: done lasts one cycle unless an immediate zero-period restart follows
    a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !(start_i && period_i == '0)) |=> !done_i);

    // R2: words and granularity move only in the done cycle
    a_r2_words_change_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |-> ($stable(strobe_i) && $stable(cycle_i) && $stable(half_i)));

    // R6: a failed conversion leaves the words untouched
    a_r6_hold_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && err_i) |-> ($stable(strobe_i) && $stable(cycle_i) && $stable(half_i)));

    // R3 and R4: ordering between delivered fields on success
    a_r4_ordering_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !err_i) |->
            ((strobe_i[19:14] > 6'(strobe_i[13:10]))
          && (strobe_i[29:24] > 6'(strobe_i[23:20]))
          && (strobe_i[9:4]   > 6'(strobe_i[3:0]))
          && (strobe_i[9:4]  >= strobe_i[19:14])
          && (strobe_i[9:4]  >= strobe_i[29:24])
          && (cycle_i[27:22]  > 6'(strobe_i[23:20]))
          && (cycle_i[5:0]   >= strobe_i[19:14])
          && (cycle_i[11:6]  >= strobe_i[29:24])));
endmodule

bind tmc_tick_converter tmc_checker #(.PER_W(PER_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .period_i (period_ps_i),
    .strobe_i (strobe_word_o),
    .cycle_i  (cycle_word_o),
    .half_i   (half_rate_o),
    .done_i   (done_o),
    .err_i    (err_o)
);

// File: tb/sim_tmc_tick_converter.sv
`timescale 1ns/1ps
module sim_tmc_tick_converter;
    localparam int TIME_W = 24;
    localparam int PER_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PER_W-1:0] period = '0;
    logic [TIME_W-1:0] tin [10];
    logic [31:0] w0, w1;
    logic gran, done, err;

    int compared = 0;
    int mismatched = 0;
    longint tv [10];
    logic [31:0] exp_w0 = '0, exp_w1 = '0;
    logic exp_gran = 1'b0;

    always #5 clk = ~clk;

    tmc_tick_converter #(.TIME_W(TIME_W), .PER_W(PER_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_ps_i(period),
        .cs_on_ps_i(tin[0]), .cs_off_ps_i(tin[1]),
        .wr_on_ps_i(tin[2]), .wr_off_ps_i(tin[3]),
        .rd_on_ps_i(tin[4]), .rd_off_ps_i(tin[5]),
        .wr_cycle_ps_i(tin[6]), .rd_cycle_ps_i(tin[7]),
        .rd_access_ps_i(tin[8]), .cs_pulse_ps_i(tin[9]),
        .strobe_word_o(w0), .cycle_word_o(w1), .half_rate_o(gran),
        .done_o(done), .err_o(err)
    );

    function automatic longint mx(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic cmp(string tag, logic e_done, logic e_err);
        compared++;
        if (done !== e_done || err !== e_err || w0 !== exp_w0 || w1 !== exp_w1 || gran !== exp_gran) begin
            mismatched++;
            $display("FAIL %s: got done=%b err=%b w0=%h w1=%h gran=%b exp done=%b err=%b w0=%h w1=%h gran=%b",
                     tag, done, err, w0, w1, gran, e_done, e_err, exp_w0, exp_w1, exp_gran);
        end
    endtask

    // behavioural model of the requirements: result words and latency
    task automatic model(input longint per, output bit ok, output logic [31:0] e0,
                         output logic [31:0] e1, output logic eg, output int lat);
        longint c [10];
        longint cson, csoff, weon, weoff, reon, reoff, wcyc, rcyc, acc, pw, s;
        ok = 1'b0; e0 = '0; e1 = '0; eg = 1'b0; lat = 0;
        if (per == 0) return;
        for (int dv = 1; dv <= 2 && !ok; dv++) begin
            s = per * dv;
            lat += 1;
            for (int i = 0; i < 10; i++) begin
                c[i] = (tv[i] + s - 1) / s;
                lat += int'((c[i] > 64) ? 64 : c[i]) + 2;
            end
            cson = c[0]; weon = c[2]; reon = c[4]; pw = c[9];
            weoff = mx(c[3], weon + 1);
            reoff = mx(c[5], reon + 1);
            csoff = mx(mx(c[1], cson + 1), mx(weoff, reoff));
            acc   = mx(c[8], reon + 1);
            wcyc  = mx(c[6], weoff);
            rcyc  = mx(c[7], reoff);
            if (cson <= 15 && weon <= 15 && reon <= 15 && csoff <= 63 && weoff <= 63
                && reoff <= 63 && wcyc <= 63 && rcyc <= 63 && acc <= 63 && pw <= 63) begin
                ok = 1'b1;
                eg = logic'(dv - 1);
                e0 = 32'(cson | (csoff << 4) | (weon << 10) | (weoff << 14) | (reon << 20) | (reoff << 24));
                e1 = 32'(wcyc | (rcyc << 6) | (pw << 12) | (acc << 22));
            end
        end
    endtask

    task automatic run(string tag, longint per);
        bit ok;
        logic [31:0] e0, e1;
        logic eg;
        int lat;
        model(per, ok, e0, e1, eg, lat);
        @(negedge clk);
        period = PER_W'(per);
        for (int i = 0; i < 10; i++) tin[i] = TIME_W'(tv[i]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) @(negedge clk);
            if (k == lat) begin
                if (ok) begin exp_w0 = e0; exp_w1 = e1; exp_gran = eg; end
                cmp(tag, 1'b1, !ok);
            end else begin
                cmp(tag, 1'b0, 1'b0);
            end
        end
        @(negedge clk);
        cmp(tag, 1'b0, 1'b0);
    endtask

    task automatic set_tv(longint a0, longint a1, longint a2, longint a3, longint a4,
                          longint a5, longint a6, longint a7, longint a8, longint a9);
        tv[0] = a0; tv[1] = a1; tv[2] = a2; tv[3] = a3; tv[4] = a4;
        tv[5] = a5; tv[6] = a6; tv[7] = a7; tv[8] = a8; tv[9] = a9;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) tin[i] = '0;
        repeat (3) @(negedge clk);
        cmp("R10 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R10 after release", 1'b0, 1'b0);

        // R1 R2: plain conversion, no repair needed
        set_tv(1000, 9000, 2001, 6000, 1500, 7000, 10000, 12000, 5000, 3000);
        run("R1 R2 basic", 1000);
        // R3 R4: off edges and cycles forced by the ordering rules
        set_tv(2000, 0, 4000, 0, 5000, 0, 0, 0, 0, 0);
        run("R3 R4 repair", 1000);
        // R5: on value exactly at the limit stays on divider 1
        set_tv(0, 20000, 15000, 20000, 0, 1000, 20000, 1000, 1000, 0);
        run("R5 on limit 15", 1000);
        // R5: on value one above the limit falls back to divider 2
        set_tv(0, 20000, 16000, 20000, 0, 1000, 20000, 1000, 1000, 0);
        run("R5 on 16 fallback", 1000);
        // R5 R8: off value overflowing on divider 1
        set_tv(500, 3000, 1000, 70000, 1000, 3000, 0, 0, 2000, 1000);
        run("R5 R8 off fallback", 1000);
        // R6: both dividers fail, words held
        set_tv(0, 0, 0, 200000, 0, 0, 0, 0, 0, 0);
        run("R6 both fail", 1000);
        // R7: zero period rejected
        set_tv(1000, 2000, 1000, 2000, 1000, 2000, 3000, 3000, 2000, 1000);
        run("R7 zero period", 0);
        // R1: non-multiple times, pulse exactly 63 ticks
        set_tv(8, 50, 14, 15, 1, 43, 99, 100, 22, 441);
        run("R1 ceiling exact", 7);
        // R1 R5: pulse 64 ticks on divider 1, 32 on divider 2
        set_tv(8, 50, 14, 15, 1, 43, 99, 100, 22, 442);
        run("R1 R5 pulse edge", 7);
        // R8: saturating count bounds the latency; still fails
        set_tv(0, 0, 0, 24'hFFFFFF, 0, 0, 0, 0, 0, 0);
        run("R8 R6 saturated", 1);
        // R9 R2: back-to-back successes, done a single pulse each time
        set_tv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run("R9 R2 all zero", 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule